// File: doc/BRIEF.md
# Bounding-Box Refit Engine

This block updates the bounds stored in a bounding-interval tree after the geometry under it has moved. The tree's structure stays as it is. A driver prepares a program of instructions for each dynamic object. The engine runs that program from a valid/ready instruction stream and takes vertex coordinates from a second valid/ready stream. Shared mesh vertices are loaded once into a local vertex register file and then reused by every triangle that touches them. Because of this reuse, the engine needs no cache.

Every result is made with signed minimum and maximum operations on fixed-point coordinates. Triangle boxes and merged boxes are kept in a separate bound register file, and the program works bottom-up from the leaves to the root. For each tree node, a node-write instruction sends out the extents of the node's two children along the node's split axis. The node-write uses a valid/ready handshake. A program ends with a stop instruction. The engine then parks until it is started again, and both register files keep their contents.

Top module: `bound_refit_core`

## Requirements
- R1: While reset is applied, and after it, the engine has `done`, `instr_ready`, `vtx_ready` and `node_valid` all low. It waits for `start`.
- R2: A `start` pulse given while the engine is idle or finished raises `instr_ready` in the next cycle and clears `done`.
- R3: Instruction bits [2:0] hold the opcode and bits [8:3] hold the destination index. Opcode 1 loads a vertex. Once it is accepted, `instr_ready` drops and `vtx_ready` rises. The next vertex beat, laid out as x in [15:0], y in [31:16] and z in [47:32], is written into the vertex register named by the destination index.
- R4: Opcode 2 reads the three vertex registers named by bits [14:9], [20:15] and [26:21]. On each axis it writes the signed minimum and the signed maximum of those vertices into the bound register named by bits [8:3].
- R5: Opcode 3 writes the per-axis union of bound registers [14:9] and [20:15] into bound register [8:3]: the minimum of the minima and the maximum of the maxima. The destination may be one of the sources, and the next instruction then sees the new value.
- R6: Opcode 4 raises `node_valid` in the cycle after it is accepted. It presents the node address from bits [44:29], and the min/max of bound register [14:9] as child 0 and of bound register [20:15] as child 1, taken along the axis in bits [28:27]. Axis code 0 selects x, 1 selects y, and 2 or 3 select z.
- R7: While `node_valid` is high and `node_ready` is low, every node output stays stable and no instruction is accepted. The output is released in the cycle after `node_ready` is sampled high.
- R8: Opcode 7 raises `done` in the next cycle. Instruction fetch then stays blocked until `start`. The register contents survive the restart.
- R9: Opcodes 0, 5 and 6 change no register and start no vertex or node transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin running the instruction stream |
| instr_valid | input | 1 | Instruction word is offered |
| instr_ready | output | 1 | Engine accepts an instruction this cycle |
| instr_data | input | 45 | Instruction word |
| vtx_valid | input | 1 | Vertex beat is offered |
| vtx_ready | output | 1 | Engine waits for a vertex beat |
| vtx_data | input | 48 | Vertex coordinates {z, y, x}, signed 16-bit each |
| node_valid | output | 1 | Node extents are presented |
| node_ready | input | 1 | Consumer takes the node extents |
| node_addr | output | 16 | Address of the node being written |
| c0_lo | output | 16 | Child 0 lower bound on the split axis |
| c0_hi | output | 16 | Child 0 upper bound on the split axis |
| c1_lo | output | 16 | Child 1 lower bound on the split axis |
| c1_hi | output | 16 | Child 1 upper bound on the split axis |
| done | output | 1 | Stop instruction reached |

## Verification
A merge can write a bound register while that same register is one of its own sources. In that cycle the read of the old value and the write of the new one happen together. The bench provokes this with an accumulating merge whose destination equals its first source, followed with no idle cycle by a node-write that reads the same register. It judges the result by comparing the emitted extents with a union computed from the bench's own box model. The bench also holds back the node-write handshake while further instructions wait, and checks that neither the outputs nor the register files move.

// File: rtl/refit_pkg.sv
package refit_pkg;

  // Operation codes carried in the low three bits of an instruction word.
  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_LDV = 3'd1;
  localparam logic [2:0] OP_TRI = 3'd2;
  localparam logic [2:0] OP_MRG = 3'd3;
  localparam logic [2:0] OP_NWR = 3'd4;
  localparam logic [2:0] OP_END = 3'd7;

  localparam int OPC_W = 3;
  localparam int AXIS_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_WVTX = 3'd2,
    ST_EMIT = 3'd3,
    ST_DONE = 3'd4
  } refit_state_e;

endpackage

// File: rtl/refit_decode.sv
module refit_decode
  import refit_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ADDR_W = 16,
  localparam int DST_LSB = OPC_W,
  localparam int SA_LSB = DST_LSB + IDX_W,
  localparam int SB_LSB = SA_LSB + IDX_W,
  localparam int SC_LSB = SB_LSB + IDX_W,
  localparam int AX_LSB = SC_LSB + IDX_W,
  localparam int ADR_LSB = AX_LSB + AXIS_W,
  localparam int INSTR_W = ADR_LSB + ADDR_W
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [OPC_W-1:0]   opcode,
  output logic [IDX_W-1:0]   dst,
  output logic [IDX_W-1:0]   src_a,
  output logic [IDX_W-1:0]   src_b,
  output logic [IDX_W-1:0]   src_c,
  output logic [AXIS_W-1:0]  axis,
  output logic [ADDR_W-1:0]  naddr
);

  assign opcode = instr[0 +: OPC_W];
  assign dst    = instr[DST_LSB +: IDX_W];
  assign src_a  = instr[SA_LSB +: IDX_W];
  assign src_b  = instr[SB_LSB +: IDX_W];
  assign src_c  = instr[SC_LSB +: IDX_W];
  assign axis   = instr[AX_LSB +: AXIS_W];
  assign naddr  = instr[ADR_LSB +: ADDR_W];

endmodule

// File: rtl/refit_regfile.sv
module refit_regfile #(
  parameter int DEPTH = 64,
  parameter int AW = 6,
  parameter int WIDTH = 48,
  parameter int NRD = 2
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [WIDTH-1:0]   wdata,
  input  logic [NRD*AW-1:0]  raddr,
  output logic [NRD*WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r*WIDTH +: WIDTH] = mem[raddr[r*AW +: AW]];
  end

endmodule

// File: rtl/refit_box_alu.sv
module refit_box_alu #(
  parameter int CW = 16,
  localparam int VW = 3 * CW,
  localparam int BW = 6 * CW
) (
  input  logic [VW-1:0] va,
  input  logic [VW-1:0] vb,
  input  logic [VW-1:0] vc,
  input  logic [BW-1:0] ba,
  input  logic [BW-1:0] bb,
  output logic [BW-1:0] tri_box,
  output logic [BW-1:0] mrg_box
);

  // Box layout: minima in the low three lanes, maxima in the high three.
  for (genvar ax = 0; ax < 3; ax++) begin : g_axis
    logic signed [CW-1:0] pa, pb, pc;
    logic signed [CW-1:0] lo_ab, hi_ab, lo_t, hi_t;
    logic signed [CW-1:0] amin, amax, bmin, bmax;

    assign pa = va[ax*CW +: CW];
    assign pb = vb[ax*CW +: CW];
    assign pc = vc[ax*CW +: CW];
    assign lo_ab = (pa < pb) ? pa : pb;
    assign hi_ab = (pa > pb) ? pa : pb;
    assign lo_t  = (lo_ab < pc) ? lo_ab : pc;
    assign hi_t  = (hi_ab > pc) ? hi_ab : pc;
    assign tri_box[ax*CW +: CW]     = lo_t;
    assign tri_box[(ax+3)*CW +: CW] = hi_t;

    assign amin = ba[ax*CW +: CW];
    assign amax = ba[(ax+3)*CW +: CW];
    assign bmin = bb[ax*CW +: CW];
    assign bmax = bb[(ax+3)*CW +: CW];
    assign mrg_box[ax*CW +: CW]     = (amin < bmin) ? amin : bmin;
    assign mrg_box[(ax+3)*CW +: CW] = (amax > bmax) ? amax : bmax;
  end

endmodule

// File: rtl/bound_refit_core.sv
module bound_refit_core
  import refit_pkg::*;
#(
  parameter int CW = 16,
  parameter int NVTX = 64,
  parameter int NBND = 64,
  parameter int ADDR_W = 16,
  localparam int NMAX = (NVTX > NBND) ? NVTX : NBND,
  localparam int IDX_W = $clog2(NMAX),
  localparam int INSTR_W = OPC_W + 4 * IDX_W + AXIS_W + ADDR_W,
  localparam int VW = 3 * CW,
  localparam int BW = 6 * CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_data,
  input  logic               vtx_valid,
  output logic               vtx_ready,
  input  logic [VW-1:0]      vtx_data,
  output logic               node_valid,
  input  logic               node_ready,
  output logic [ADDR_W-1:0]  node_addr,
  output logic [CW-1:0]      c0_lo,
  output logic [CW-1:0]      c0_hi,
  output logic [CW-1:0]      c1_lo,
  output logic [CW-1:0]      c1_hi,
  output logic               done
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[1];

  // Decode
  logic [OPC_W-1:0]  opcode;
  logic [IDX_W-1:0]  dst, src_a, src_b, src_c;
  logic [AXIS_W-1:0] axis;
  logic [ADDR_W-1:0] naddr;

  refit_decode #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) dec_i (
    .instr (instr_data),
    .opcode(opcode),
    .dst   (dst),
    .src_a (src_a),
    .src_b (src_b),
    .src_c (src_c),
    .axis  (axis),
    .naddr (naddr)
  );

  // Control
  refit_state_e state_q, state_d;
  logic         accept;

  assign instr_ready = (state_q == ST_RUN);
  assign vtx_ready   = (state_q == ST_WVTX);
  assign node_valid  = (state_q == ST_EMIT);
  assign done        = (state_q == ST_DONE);
  assign accept      = instr_valid && instr_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_RUN;
      ST_RUN: begin
        if (accept) begin
          if (opcode == OP_LDV)      state_d = ST_WVTX;
          else if (opcode == OP_NWR) state_d = ST_EMIT;
          else if (opcode == OP_END) state_d = ST_DONE;
        end
      end
      ST_WVTX: if (vtx_valid) state_d = ST_RUN;
      ST_EMIT: if (node_ready) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Vertex destination held while waiting for the vertex beat.
  logic             vdst_en;
  logic [IDX_W-1:0] vdst_q;

  assign vdst_en = accept && (opcode == OP_LDV);

  always_ff @(posedge clk) begin
    if (vdst_en) begin
      vdst_q <= dst;
    end
  end

  // Register files
  logic            vrf_we;
  logic [3*VW-1:0] vrf_rd;
  logic            brf_we;
  logic [BW-1:0]   brf_wd;
  logic [2*BW-1:0] brf_rd;
  logic [BW-1:0]   tri_box, mrg_box;

  assign vrf_we = (state_q == ST_WVTX) && vtx_valid;

  refit_regfile #(.DEPTH(NVTX), .AW(IDX_W), .WIDTH(VW), .NRD(3)) vrf_i (
    .clk  (clk),
    .we   (vrf_we),
    .waddr(vdst_q),
    .wdata(vtx_data),
    .raddr({src_c, src_b, src_a}),
    .rdata(vrf_rd)
  );

  assign brf_we = accept && ((opcode == OP_TRI) || (opcode == OP_MRG));
  assign brf_wd = (opcode == OP_TRI) ? tri_box : mrg_box;

  refit_regfile #(.DEPTH(NBND), .AW(IDX_W), .WIDTH(BW), .NRD(2)) brf_i (
    .clk  (clk),
    .we   (brf_we),
    .waddr(dst),
    .wdata(brf_wd),
    .raddr({src_b, src_a}),
    .rdata(brf_rd)
  );

  refit_box_alu #(.CW(CW)) alu_i (
    .va     (vrf_rd[0 +: VW]),
    .vb     (vrf_rd[VW +: VW]),
    .vc     (vrf_rd[2*VW +: VW]),
    .ba     (brf_rd[0 +: BW]),
    .bb     (brf_rd[BW +: BW]),
    .tri_box(tri_box),
    .mrg_box(mrg_box)
  );

  // Node extent selection along the split axis (codes 2 and 3 pick z).
  logic [1:0]    ax_sel;
  logic [CW-1:0] s0_lo, s0_hi, s1_lo, s1_hi;
  logic          nwr_en;

  assign ax_sel = (axis == 2'd3) ? 2'd2 : axis;
  assign s0_lo  = brf_rd[int'(ax_sel)*CW +: CW];
  assign s0_hi  = brf_rd[(int'(ax_sel)+3)*CW +: CW];
  assign s1_lo  = brf_rd[BW + int'(ax_sel)*CW +: CW];
  assign s1_hi  = brf_rd[BW + (int'(ax_sel)+3)*CW +: CW];
  assign nwr_en = accept && (opcode == OP_NWR);

  always_ff @(posedge clk) begin
    if (nwr_en) begin
      node_addr <= naddr;
      c0_lo     <= s0_lo;
      c0_hi     <= s0_hi;
      c1_lo     <= s1_lo;
      c1_hi     <= s1_hi;
    end
  end

endmodule

// File: rtl/refit_checker.sv
module refit_checker #(
  parameter int CW = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [2:0]        op,
  input logic [ADDR_W-1:0] adr,
  input logic              vtx_ready,
  input logic              node_valid,
  input logic              node_ready,
  input logic [ADDR_W-1:0] node_addr,
  input logic [CW-1:0]     c0_lo,
  input logic [CW-1:0]     c0_hi,
  input logic [CW-1:0]     c1_lo,
  input logic [CW-1:0]     c1_hi,
  input logic              done
);

  p_one_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_ready && vtx_ready) && !(instr_ready && node_valid));

  p_ldv_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && op == 3'd1) |=> (vtx_ready && !instr_ready));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !instr_ready && !vtx_ready && !node_valid) |=> (instr_ready && !done));

  p_nwr_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && op == 3'd4) |=> (node_valid && node_addr == $past(adr)));

  p_node_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (node_valid && !node_ready) |=> (node_valid && $stable(node_addr) && $stable(c0_lo)
      && $stable(c0_hi) && $stable(c1_lo) && $stable(c1_hi)));

  p_node_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (node_valid && node_ready) |=> (!node_valid && instr_ready));

  p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && op == 3'd7) |=> done);

  p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !instr_ready);

  p_quiet_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && (op == 3'd0 || op == 3'd5 || op == 3'd6))
      |=> (instr_ready && !vtx_ready && !node_valid));

endmodule

bind bound_refit_core refit_checker #(.CW(CW), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n_i),
  .start      (start),
  .instr_valid(instr_valid),
  .instr_ready(instr_ready),
  .op         (instr_data[2:0]),
  .adr        (instr_data[INSTR_W-1 -: ADDR_W]),
  .vtx_ready  (vtx_ready),
  .node_valid (node_valid),
  .node_ready (node_ready),
  .node_addr  (node_addr),
  .c0_lo      (c0_lo),
  .c0_hi      (c0_hi),
  .c1_lo      (c1_lo),
  .c1_hi      (c1_hi),
  .done       (done)
);

// File: tb/bound_refit_core_tb.sv
module bound_refit_core_tb_top;

  localparam int CW = 16;
  localparam int AW = 16;
  localparam int IW = 45;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          instr_valid;
  logic          instr_ready;
  logic [IW-1:0] instr_data;
  logic          vtx_valid;
  logic          vtx_ready;
  logic [3*CW-1:0] vtx_data;
  logic          node_valid;
  logic          node_ready;
  logic [AW-1:0] node_addr;
  logic [CW-1:0] c0_lo, c0_hi, c1_lo, c1_hi;
  logic          done;

  always #10 clk = ~clk;

  bound_refit_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_data(instr_data),
    .vtx_valid(vtx_valid), .vtx_ready(vtx_ready), .vtx_data(vtx_data),
    .node_valid(node_valid), .node_ready(node_ready), .node_addr(node_addr),
    .c0_lo(c0_lo), .c0_hi(c0_hi), .c1_lo(c1_lo), .c1_hi(c1_hi), .done(done)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model of both register files.
  int vm [64][3];
  int bmin [64][3];
  int bmax [64][3];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(int op, int d, int a, int b, int c, int ax, int adr);
    logic [IW-1:0] w;
    w = '0;
    w[2:0]   = op[2:0];
    w[8:3]   = d[5:0];
    w[14:9]  = a[5:0];
    w[20:15] = b[5:0];
    w[26:21] = c[5:0];
    w[28:27] = ax[1:0];
    w[44:29] = adr[15:0];
    return w;
  endfunction

  function automatic longint sx(logic [CW-1:0] v);
    return longint'($signed(v));
  endfunction

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic push(input logic [IW-1:0] w);
    instr_data = w;
    instr_valid = 1'b1;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic load_vertex(input int idx, input int x, input int y, input int z);
    push(mk(1, idx, 0, 0, 0, 0, 0));
    check(instr_ready == 1'b0 && vtx_ready == 1'b1, "R3", "ready swap", vtx_ready, 1);
    vtx_data = {z[15:0], y[15:0], x[15:0]};
    vtx_valid = 1'b1;
    while (!vtx_ready) @(negedge clk);
    @(negedge clk);
    vtx_valid = 1'b0;
    vm[idx][0] = x; vm[idx][1] = y; vm[idx][2] = z;
  endtask

  task automatic tri_box(input int d, input int a, input int b, input int c);
    push(mk(2, d, a, b, c, 0, 0));
    for (int ax = 0; ax < 3; ax++) begin
      int lo, hi;
      lo = vm[a][ax]; hi = vm[a][ax];
      if (vm[b][ax] < lo) lo = vm[b][ax];
      if (vm[c][ax] < lo) lo = vm[c][ax];
      if (vm[b][ax] > hi) hi = vm[b][ax];
      if (vm[c][ax] > hi) hi = vm[c][ax];
      bmin[d][ax] = lo; bmax[d][ax] = hi;
    end
  endtask

  task automatic merge_box(input int d, input int a, input int b);
    int lo [3];
    int hi [3];
    push(mk(3, d, a, b, 0, 0, 0));
    for (int ax = 0; ax < 3; ax++) begin
      lo[ax] = (bmin[a][ax] < bmin[b][ax]) ? bmin[a][ax] : bmin[b][ax];
      hi[ax] = (bmax[a][ax] > bmax[b][ax]) ? bmax[a][ax] : bmax[b][ax];
    end
    for (int ax = 0; ax < 3; ax++) begin
      bmin[d][ax] = lo[ax]; bmax[d][ax] = hi[ax];
    end
  endtask

  task automatic nwr_check(input int adr, input int a, input int b, input int axis,
                           input string req);
    int ex;
    ex = (axis == 3) ? 2 : axis;
    push(mk(4, 0, a, b, 0, axis, adr));
    check(node_valid == 1'b1, req, "node_valid", node_valid, 1);
    check(node_addr == adr[15:0], req, "node_addr", node_addr, adr);
    check(sx(c0_lo) == bmin[a][ex], req, "c0_lo", sx(c0_lo), bmin[a][ex]);
    check(sx(c0_hi) == bmax[a][ex], req, "c0_hi", sx(c0_hi), bmax[a][ex]);
    check(sx(c1_lo) == bmin[b][ex], req, "c1_lo", sx(c1_lo), bmin[b][ex]);
    check(sx(c1_hi) == bmax[b][ex], req, "c1_hi", sx(c1_hi), bmax[b][ex]);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(done == 1'b0, "R1", "done", done, 0);
    check(instr_ready == 1'b0, "R1", "instr_ready", instr_ready, 0);
    check(vtx_ready == 1'b0, "R1", "vtx_ready", vtx_ready, 0);
    check(node_valid == 1'b0, "R1", "node_valid", node_valid, 0);
  endtask

  task automatic t_start;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(instr_ready == 1'b1, "R2", "instr_ready after start", instr_ready, 1);
    check(done == 1'b0, "R2", "done after start", done, 0);
  endtask

  task automatic t_load_tri;
    load_vertex(0, 10, -5, 3);
    load_vertex(1, -7, 20, 3);
    load_vertex(2, 4, 1, -9);
    load_vertex(63, -1, -2, -3);
    load_vertex(63, -4, 8, -12);   // overwrite of the last index (R3)
    tri_box(1, 0, 1, 2);
    tri_box(63, 63, 63, 63);       // degenerate box (R4)
    nwr_check(16'h0011, 1, 63, 0, "R4");
    nwr_check(16'h0012, 1, 63, 2, "R3");
  endtask

  task automatic t_merge;
    load_vertex(3, 100, -100, 0);
    load_vertex(4, -32768, 5, 7);
    load_vertex(5, 32767, 6, -1);
    tri_box(2, 3, 4, 5);
    merge_box(3, 1, 2);
    nwr_check(16'h0100, 3, 2, 1, "R5");
    nwr_check(16'h0101, 3, 1, 0, "R6");
    nwr_check(16'hFFFF, 2, 3, 3, "R6");
  endtask

  task automatic t_merge_self;
    merge_box(1, 1, 63);           // destination equals first source
    nwr_check(16'h0200, 1, 1, 1, "R5");
    nwr_check(16'h0201, 1, 2, 2, "R5");
  endtask

  task automatic t_quiet_ops;
    push(mk(0, 2, 3, 3, 3, 0, 0));
    push(mk(5, 2, 3, 3, 3, 0, 0));
    push(mk(6, 2, 3, 3, 3, 0, 0));
    check(vtx_ready == 1'b0 && node_valid == 1'b0 && done == 1'b0, "R9",
          "no transfer started", {vtx_ready, node_valid, done}, 0);
    nwr_check(16'h0300, 2, 2, 0, "R9");
    nwr_check(16'h0301, 2, 2, 1, "R9");
  endtask

  task automatic t_backpressure;
    node_ready = 1'b0;
    push(mk(4, 0, 3, 1, 0, 2, 16'hBEEF));
    instr_data = mk(4, 0, 2, 2, 0, 0, 16'h1234);
    instr_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(node_valid == 1'b1 && node_addr == 16'hBEEF, "R7", "held addr", node_addr, 16'hBEEF);
      check(sx(c0_lo) == bmin[3][2] && sx(c1_hi) == bmax[1][2], "R7", "held c0_lo",
            sx(c0_lo), bmin[3][2]);
      check(instr_ready == 1'b0, "R7", "instr blocked", instr_ready, 0);
    end
    instr_valid = 1'b0;
    node_ready = 1'b1;
    @(negedge clk);
    check(node_valid == 1'b0 && instr_ready == 1'b1, "R7", "release", node_valid, 0);
  endtask

  task automatic t_end;
    push(mk(7, 0, 0, 0, 0, 0, 0));
    check(done == 1'b1, "R8", "done", done, 1);
    check(instr_ready == 1'b0, "R8", "instr_ready", instr_ready, 0);
    instr_data = mk(4, 0, 1, 1, 0, 0, 16'h7777);
    instr_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(node_valid == 1'b0 && done == 1'b1, "R8", "fetch blocked", node_valid, 0);
    instr_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(instr_ready == 1'b1 && done == 1'b0, "R8", "restart", instr_ready, 1);
    nwr_check(16'h0400, 3, 63, 1, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    instr_valid = 1'b0;
    instr_data = '0;
    vtx_valid = 1'b0;
    vtx_data = '0;
    node_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start();
    t_load_tri();
    t_merge();
    t_merge_self();
    t_quiet_ops();
    t_backpressure();
    t_end();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule